// File: doc/BRIEF.md
# Shared-RAM Host Port with Strap-Selected Handshake

This block connects a 16-bit host processor bus to a 4K-word shared RAM and a small register file. An internal protocol engine uses the same RAM. The engine is modelled here as a simple request port. The host marks an access by pulling its select and strobe low. The block waits until the engine leaves the RAM free, then starts a transfer and pulls `ioen_n` low.

During the transfer, the block captures the host's control inputs on the first falling clock edge, captures the address on the next rising edge, performs the access, and then signals completion on `ready_n`. Two strap inputs set how the block meets the host bus:

- `zero_wait` chooses the ready style. With a handshake, ready is asserted once the data is in place. With zero-wait, ready idles asserted and is only withdrawn while a transfer whose strobe has already ended is still running.
- `pol_sel` chooses which level of the read/write input means write.

A separate address-latch input can capture the address ahead of a transfer.

Top module: `hsif_host_port`

## Requirements
- R1: A transfer starts only on a rising edge where `sel_n` and `strb_n` are both sampled low. `ioen_n` falls right after that edge.
- R2: If `eng_req` is high on an edge where the host request is present, the host start is deferred. `ioen_n` falls after the first edge with the request present and `eng_req` low.
- R3: `memreg_in` and `rw_in` are captured on the first falling edge after the start. Later changes to them have no effect on the transfer.
- R4: `addr_in` is captured on the first rising edge after `ioen_n` falls. Later changes to it have no effect on the transfer.
- R5: A rising edge with `addr_lat` high captures `addr_in`. Such a capture replaces the R4 capture for the next transfer.
- R6: With `zero_wait`=1, `ready_n` goes low right after the third rising edge after `ioen_n` falls. By then a write is stored, or read data is on `rdata_out` with `rdata_oe`=1.
- R7: With `zero_wait`=1, once ready is asserted, an edge that samples `strb_n` or `sel_n` high returns the block to idle. After that edge `ioen_n` and `ready_n` are both high.
- R8: With `zero_wait`=0, `ready_n` is low whenever the block is idle. It goes high after an edge that samples `strb_n` high while the transfer is incomplete. It goes low again after the third edge after `ioen_n` falls.
- R9: With `pol_sel`=0, a transfer with `rw_in`=0 is a write. With `pol_sel`=1, a transfer with `rw_in`=1 is a write. Any other combination is a read.
- R10: `memreg_in`=1 selects the 4096-word RAM, indexed by `addr_in[11:0]`. `memreg_in`=0 selects a separate 32-word register file, indexed by `addr_in[4:0]`.
- R11: `eng_gnt` is high when `eng_req` is high and no host transfer is in progress. A granted access occurs on that edge, and `eng_rdata` holds the read word after it.
- R12: After reset, `ioen_n` is high, `rdata_oe` is low, and `ready_n` equals `zero_wait`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| zero_wait | input | 1 | Strap: 1 = handshake ready, 0 = zero-wait ready |
| pol_sel | input | 1 | Strap: read/write sense |
| sel_n | input | 1 | Chip select, active low |
| strb_n | input | 1 | Strobe, active low |
| rw_in | input | 1 | Read/write direction, sense set by pol_sel |
| memreg_in | input | 1 | 1 = RAM, 0 = register file |
| addr_lat | input | 1 | Early address capture |
| addr_in | input | 12 | Host word address |
| wdata_in | input | 16 | Host write data |
| rdata_out | output | 16 | Host read data |
| rdata_oe | output | 1 | Read data valid/drive enable |
| ioen_n | output | 1 | Transfer in progress, active low |
| ready_n | output | 1 | Ready/acknowledge, active low |
| eng_req | input | 1 | Protocol engine RAM request |
| eng_we | input | 1 | Engine write enable |
| eng_addr | input | 12 | Engine RAM address |
| eng_wdata | input | 16 | Engine write data |
| eng_gnt | output | 1 | Engine granted this cycle |
| eng_rdata | output | 16 | Engine read data |

## Verification
Every result has a fixed latency, counted in clock edges:

- `ioen_n` changes one edge after the request is sampled.
- The control inputs are latched at the falling edge half a cycle later.
- The address is latched one rising edge later still.
- The RAM access and read data come on the second edge.
- In handshake mode, `ready_n` falls on the third edge.
- Release to idle takes one edge after the strobe is seen high.

The bench drives its inputs and samples the outputs 6 ns after each rising edge, which is past the falling edge. It counts edges from the fall of `ioen_n` and checks `ready_n` at each one. It changes the control and address inputs only after their capture edges, so a late capture would surface as a wrong read-back.

// File: rtl/hsif_pkg.sv
package hsif_pkg;

    parameter int unsigned HSIF_DATA_W = 16;
    parameter int unsigned HSIF_ADDR_W = 12;
    parameter int unsigned HSIF_REG_AW = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_ADDR,
        ST_ACC,
        ST_DONE
    } xfer_state_t;

    typedef struct packed {
        logic is_mem;
        logic is_wr;
    } xfer_ctrl_t;

    // Direction decode: the strap picks which rw level means write.
    function automatic logic decode_write(input logic rw, input logic pol);
        return pol ? rw : ~rw;
    endfunction

endpackage

// File: rtl/hsif_fsm.sv
module hsif_fsm
    import hsif_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        zero_wait,
    input  logic        sel_n,
    input  logic        strb_n,
    input  logic        eng_req,
    output xfer_state_t state,
    output logic        ioen_n,
    output logic        ready_n,
    output logic        eng_gnt
);

    xfer_state_t state_nx;
    logic        host_req;

    assign host_req = ~sel_n & ~strb_n;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (host_req && !eng_req) state_nx = ST_CTRL;
            ST_CTRL: state_nx = ST_ADDR;
            ST_ADDR: state_nx = ST_ACC;
            ST_ACC:  state_nx = ST_DONE;
            ST_DONE: if (sel_n || strb_n) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            ioen_n  <= 1'b1;
            ready_n <= zero_wait;
        end else begin
            state  <= state_nx;
            ioen_n <= (state_nx == ST_IDLE);
            if (zero_wait)
                ready_n <= (state_nx != ST_DONE);
            else
                ready_n <= strb_n && (state_nx inside {ST_CTRL, ST_ADDR, ST_ACC});
        end
    end

    // Engine only gets the RAM between host transfers.
    assign eng_gnt = eng_req && (state == ST_IDLE);

    assert_start_req_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(ioen_n) |-> ($past(!sel_n) && $past(!strb_n)));

    assert_defer_eng_R2: assert property (@(posedge clk) disable iff (rst)
        (ioen_n && eng_req) |=> ioen_n);

    assert_hs_ready_R6: assert property (@(posedge clk) disable iff (rst)
        (zero_wait && !ready_n) |-> !ioen_n);

    assert_zw_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (!zero_wait && ioen_n) |-> !ready_n);

endmodule

// File: rtl/hsif_capture.sv
module hsif_capture
    import hsif_pkg::*;
#(
    parameter int unsigned ADDR_W = HSIF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  xfer_state_t       state,
    input  logic              pol_sel,
    input  logic              rw_in,
    input  logic              memreg_in,
    input  logic              addr_lat,
    input  logic [ADDR_W-1:0] addr_in,
    output xfer_ctrl_t        ctrl_q,
    output logic [ADDR_W-1:0] addr_q
);

    logic addr_held;

    // Control capture on the falling edge inside the first transfer cycle.
    always_ff @(negedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (state == ST_CTRL) begin
            ctrl_q.is_mem <= memreg_in;
            ctrl_q.is_wr  <= decode_write(rw_in, pol_sel);
        end
    end

    // Address: early latch wins over the in-transfer capture edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q    <= '0;
            addr_held <= 1'b0;
        end else if (addr_lat) begin
            addr_q    <= addr_in;
            addr_held <= 1'b1;
        end else begin
            if (state == ST_CTRL && !addr_held)
                addr_q <= addr_in;
            if (state == ST_ADDR)
                addr_held <= 1'b0;
        end
    end

    assert_addr_stable_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ADDR && !addr_lat) |=> $stable(addr_q));

endmodule

// File: rtl/hsif_store.sv
module hsif_store
    import hsif_pkg::*;
#(
    parameter int unsigned DATA_W = HSIF_DATA_W,
    parameter int unsigned ADDR_W = HSIF_ADDR_W,
    parameter int unsigned REG_AW = HSIF_REG_AW
) (
    input  logic              clk,
    input  logic              rst,
    input  xfer_state_t       state,
    input  xfer_ctrl_t        ctrl_q,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic              eng_gnt,
    input  logic              eng_we,
    input  logic [ADDR_W-1:0] eng_addr,
    input  logic [DATA_W-1:0] eng_wdata,
    output logic [DATA_W-1:0] rdata_q,
    output logic [DATA_W-1:0] eng_rdata
);

    localparam int unsigned MEM_DEPTH = 1 << ADDR_W;
    localparam int unsigned REG_DEPTH = 1 << REG_AW;

    logic [DATA_W-1:0] ram [MEM_DEPTH];
    logic [DATA_W-1:0] regs [REG_DEPTH];
    logic              host_acc;
    logic [REG_DEPTH-1:0] reg_we;
    logic [REG_AW-1:0] reg_idx;

    assign host_acc = (state == ST_ADDR);
    assign reg_idx  = addr_q[REG_AW-1:0];

    for (genvar g = 0; g < REG_DEPTH; g++) begin : g_reg_dec
        assign reg_we[g] = host_acc && ctrl_q.is_wr && !ctrl_q.is_mem
                           && (reg_idx == REG_AW'(g));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < REG_DEPTH; i++) regs[i] <= '0;
        end else begin
            for (int i = 0; i < REG_DEPTH; i++)
                if (reg_we[i]) regs[i] <= wdata_in;
        end
    end

    always_ff @(posedge clk) begin
        if (host_acc && ctrl_q.is_wr && ctrl_q.is_mem)
            ram[addr_q] <= wdata_in;
        else if (eng_gnt && eng_we)
            ram[eng_addr] <= eng_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q   <= '0;
            eng_rdata <= '0;
        end else begin
            if (host_acc && !ctrl_q.is_wr)
                rdata_q <= ctrl_q.is_mem ? ram[addr_q] : regs[reg_idx];
            if (eng_gnt && !eng_we)
                eng_rdata <= ram[eng_addr];
        end
    end

    assert_no_collide_R11: assert property (@(posedge clk) disable iff (rst)
        eng_gnt |-> !host_acc);

endmodule

// File: rtl/hsif_host_port.sv
module hsif_host_port
    import hsif_pkg::*;
#(
    parameter int unsigned DATA_W = HSIF_DATA_W,
    parameter int unsigned ADDR_W = HSIF_ADDR_W,
    parameter int unsigned REG_AW = HSIF_REG_AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              zero_wait,
    input  logic              pol_sel,
    input  logic              sel_n,
    input  logic              strb_n,
    input  logic              rw_in,
    input  logic              memreg_in,
    input  logic              addr_lat,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] wdata_in,
    output logic [DATA_W-1:0] rdata_out,
    output logic              rdata_oe,
    output logic              ioen_n,
    output logic              ready_n,
    input  logic              eng_req,
    input  logic              eng_we,
    input  logic [ADDR_W-1:0] eng_addr,
    input  logic [DATA_W-1:0] eng_wdata,
    output logic              eng_gnt,
    output logic [DATA_W-1:0] eng_rdata
);

    xfer_state_t       state;
    xfer_ctrl_t        ctrl_q;
    logic [ADDR_W-1:0] addr_q;

    hsif_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .zero_wait (zero_wait),
        .sel_n     (sel_n),
        .strb_n    (strb_n),
        .eng_req   (eng_req),
        .state     (state),
        .ioen_n    (ioen_n),
        .ready_n   (ready_n),
        .eng_gnt   (eng_gnt)
    );

    hsif_capture #(.ADDR_W(ADDR_W)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .pol_sel   (pol_sel),
        .rw_in     (rw_in),
        .memreg_in (memreg_in),
        .addr_lat  (addr_lat),
        .addr_in   (addr_in),
        .ctrl_q    (ctrl_q),
        .addr_q    (addr_q)
    );

    hsif_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_AW(REG_AW)) u_store (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .ctrl_q    (ctrl_q),
        .addr_q    (addr_q),
        .wdata_in  (wdata_in),
        .eng_gnt   (eng_gnt),
        .eng_we    (eng_we),
        .eng_addr  (eng_addr),
        .eng_wdata (eng_wdata),
        .rdata_q   (rdata_out),
        .eng_rdata (eng_rdata)
    );

    assign rdata_oe = (state inside {ST_ACC, ST_DONE}) && !ctrl_q.is_wr;

    assert_oe_in_xfer_R6: assert property (@(posedge clk) disable iff (rst)
        rdata_oe |-> !ioen_n);

    assert_gnt_idle_R11: assert property (@(posedge clk) disable iff (rst)
        eng_gnt |-> ioen_n);

endmodule

// File: tb/hsif_host_port_tb_top.sv
`timescale 1ns/1ps
module hsif_host_port_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        zero_wait = 1'b1, pol_sel = 1'b0;
    logic        sel_n = 1'b1, strb_n = 1'b1, rw_in = 1'b1, memreg_in = 1'b1;
    logic        addr_lat = 1'b0;
    logic [11:0] addr_in = '0;
    logic [15:0] wdata_in = '0;
    logic [15:0] rdata_out;
    logic        rdata_oe, ioen_n, ready_n;
    logic        eng_req = 1'b0, eng_we = 1'b0;
    logic [11:0] eng_addr = '0;
    logic [15:0] eng_wdata = '0;
    logic        eng_gnt;
    logic [15:0] eng_rdata;

    int nchk = 0;
    int nfail = 0;

    logic [15:0] mem_m [4096];
    logic [15:0] reg_m [32];
    logic [11:0] wlist [64];
    int          wcnt = 0;

    always #4 clk = ~clk;

    hsif_host_port dut_i (
        .clk(clk), .rst(rst), .zero_wait(zero_wait), .pol_sel(pol_sel),
        .sel_n(sel_n), .strb_n(strb_n), .rw_in(rw_in), .memreg_in(memreg_in),
        .addr_lat(addr_lat), .addr_in(addr_in), .wdata_in(wdata_in),
        .rdata_out(rdata_out), .rdata_oe(rdata_oe), .ioen_n(ioen_n),
        .ready_n(ready_n), .eng_req(eng_req), .eng_we(eng_we),
        .eng_addr(eng_addr), .eng_wdata(eng_wdata), .eng_gnt(eng_gnt),
        .eng_rdata(eng_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_read(input logic mem, input logic [11:0] a);
        return mem ? mem_m[a] : reg_m[a[4:0]];
    endfunction

    function automatic logic rw_level(input logic wr, input logic pol);
        return pol ? wr : ~wr;
    endfunction

    // Advance one clock: return 6 ns after the next rising edge.
    task automatic step();
        @(posedge clk);
        #6;
    endtask

    task automatic do_reset(input logic zw, input logic pol);
        rst = 1'b1; zero_wait = zw; pol_sel = pol;
        sel_n = 1'b1; strb_n = 1'b1; eng_req = 1'b0; addr_lat = 1'b0;
        repeat (3) step();
        rst = 1'b0;
        step();
        chk("R12 ioen_n after reset", 32'(ioen_n), 32'd1);
        chk("R12 rdata_oe after reset", 32'(rdata_oe), 32'd0);
        chk("R12 ready_n after reset", 32'(ready_n), 32'(zw));
        for (int i = 0; i < 32; i++) reg_m[i] = '0;
    endtask

    // Handshake-mode access. Called and returns 6 ns after a rising edge.
    task automatic hs_access(input logic mem, input logic wr, input logic [11:0] a,
                             input logic [15:0] d, input int eng_hold,
                             input logic eng_during, input logic use_lat,
                             input logic [11:0] lat_a);
        logic [11:0] eff_a;
        eff_a = use_lat ? lat_a : a;
        sel_n = 1'b0; strb_n = 1'b0; memreg_in = mem;
        rw_in = rw_level(wr, pol_sel); addr_in = a; wdata_in = d;
        for (int i = 0; i < eng_hold; i++) begin
            step();
            chk("R2 start deferred while engine busy", 32'(ioen_n), 32'd1);
            chk("R11 engine granted while idle", 32'(eng_gnt), 32'd1);
            if (i == eng_hold - 1) eng_req = 1'b0;
        end
        step();
        chk("R1 ioen_n falls after request edge", 32'(ioen_n), 32'd0);
        chk("R6 ready_n not yet asserted", 32'(ready_n), 32'd1);
        // Corrupt controls after their falling-edge capture (R3).
        rw_in = ~rw_in; memreg_in = ~memreg_in;
        if (eng_during) begin eng_req = 1'b1; eng_we = 1'b0; end
        for (int k = 1; k <= 3; k++) begin
            step();
            if (k < 3) chk("R6 ready_n high before third edge", 32'(ready_n), 32'd1);
            else       chk("R6 ready_n low on third edge", 32'(ready_n), 32'd0);
            if (eng_during && k < 3) chk("R11 no grant during host transfer", 32'(eng_gnt), 32'd0);
            if (eng_during && k == 2) eng_req = 1'b0;
            if (k == 1) addr_in = ~addr_in; // after R4 capture
        end
        chk("R6 rdata_oe reflects direction", 32'(rdata_oe), 32'(!wr));
        if (wr) begin
            if (mem) mem_m[eff_a] = d; else reg_m[eff_a[4:0]] = d;
        end else begin
            chk("R3 R4 R9 R10 read data", 32'(rdata_out), 32'(exp_read(mem, eff_a)));
        end
        sel_n = 1'b1; strb_n = 1'b1;
        step();
        chk("R7 ioen_n released", 32'(ioen_n), 32'd1);
        chk("R7 ready_n released", 32'(ready_n), 32'd1);
    endtask

    // Zero-wait access with a one-cycle strobe.
    task automatic zw_access(input logic mem, input logic wr, input logic [11:0] a,
                             input logic [15:0] d);
        sel_n = 1'b0; strb_n = 1'b0; memreg_in = mem;
        rw_in = rw_level(wr, pol_sel); addr_in = a; wdata_in = d;
        step();
        chk("R1 ioen_n falls (zero-wait)", 32'(ioen_n), 32'd0);
        chk("R8 ready_n low while strobe held", 32'(ready_n), 32'd0);
        sel_n = 1'b1; strb_n = 1'b1; rw_in = ~rw_in; memreg_in = ~memreg_in;
        for (int k = 1; k <= 3; k++) begin
            step();
            if (k < 3) chk("R8 ready_n high after strobe ends", 32'(ready_n), 32'd1);
            else       chk("R8 ready_n low at completion", 32'(ready_n), 32'd0);
            if (k == 1) addr_in = ~addr_in;
        end
        if (wr) begin
            if (mem) mem_m[a] = d; else reg_m[a[4:0]] = d;
        end else begin
            chk("R8 R9 zero-wait read data", 32'(rdata_out), 32'(exp_read(mem, a)));
        end
        step();
        chk("R8 ioen_n released", 32'(ioen_n), 32'd1);
        chk("R8 ready_n low when idle", 32'(ready_n), 32'd0);
    endtask

    initial begin
        #(8 * 150000);
        nfail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

    initial begin
        logic [11:0] a;
        logic [15:0] d;
        void'($urandom(32'd20240611));
        @(posedge clk); #6;

        // Handshake mode, write-when-low sense (R9 pol_sel=0).
        do_reset(1'b1, 1'b0);
        hs_access(1'b1, 1'b1, 12'h123, 16'hA5A5, 0, 1'b0, 1'b0, '0);
        hs_access(1'b1, 1'b0, 12'h123, 16'h0, 0, 1'b0, 1'b0, '0);
        // R10: register and RAM at same index are separate; reg index aliases.
        hs_access(1'b0, 1'b1, 12'h005, 16'h1357, 0, 1'b0, 1'b0, '0);
        hs_access(1'b1, 1'b1, 12'h005, 16'h2468, 0, 1'b0, 1'b0, '0);
        hs_access(1'b0, 1'b0, 12'h025, 16'h0, 0, 1'b0, 1'b0, '0);
        hs_access(1'b1, 1'b0, 12'h005, 16'h0, 0, 1'b0, 1'b0, '0);

        // R2/R11: engine writes while host waits, then host reads it back.
        eng_req = 1'b1; eng_we = 1'b1; eng_addr = 12'hFFF; eng_wdata = 16'hC0DE;
        mem_m[12'hFFF] = 16'hC0DE;
        hs_access(1'b1, 1'b0, 12'hFFF, 16'h0, 3, 1'b0, 1'b0, '0);
        // R11: engine request during host transfer waits; then engine read.
        eng_addr = 12'h123;
        hs_access(1'b1, 1'b0, 12'h005, 16'h0, 0, 1'b1, 1'b0, '0);
        eng_req = 1'b1; eng_we = 1'b0; eng_addr = 12'h123;
        step();
        chk("R11 engine grant", 32'(eng_gnt), 32'd1);
        chk("R11 engine read data", 32'(eng_rdata), 32'h0000A5A5);
        eng_req = 1'b0;

        // R5: early address latch overrides the in-transfer capture.
        hs_access(1'b0, 1'b1, 12'h009, 16'h1111, 0, 1'b0, 1'b0, '0);
        addr_in = 12'h003; addr_lat = 1'b1;
        step();
        addr_lat = 1'b0;
        hs_access(1'b0, 1'b1, 12'h009, 16'hBEEF, 0, 1'b0, 1'b1, 12'h003);
        hs_access(1'b0, 1'b0, 12'h003, 16'h0, 0, 1'b0, 1'b0, '0);
        chk("R5 latched address got the write", 32'(reg_m[3]), 32'h0000BEEF);
        hs_access(1'b0, 1'b0, 12'h009, 16'h0, 0, 1'b0, 1'b0, '0);

        // R1: strobe without select does not start.
        sel_n = 1'b1; strb_n = 1'b0;
        step(); step();
        chk("R1 no start without select", 32'(ioen_n), 32'd1);
        strb_n = 1'b1;
        step();

        // Random traffic, pol_sel=1 (write when rw high).
        do_reset(1'b1, 1'b1);
        wcnt = 0;
        for (int n = 0; n < 40; n++) begin
            a = 12'($urandom); d = 16'($urandom);
            hs_access(1'b1, 1'b1, a, d, 0, 1'b0, 1'b0, '0);
            if (wcnt < 64) begin wlist[wcnt] = a; wcnt++; end
            hs_access(1'b1, 1'b0, wlist[$urandom % wcnt], 16'h0, 0, 1'b0, 1'b0, '0);
            if (n % 5 == 0) begin
                hs_access(1'b0, 1'b1, a, d ^ 16'hFFFF, 0, 1'b0, 1'b0, '0);
                hs_access(1'b0, 1'b0, a, 16'h0, 0, 1'b0, 1'b0, '0);
            end
        end

        // Zero-wait mode, both senses.
        do_reset(1'b0, 1'b0);
        zw_access(1'b1, 1'b1, 12'h0A0, 16'h5A5A);
        mem_m[12'h0A0] = 16'h5A5A;
        zw_access(1'b1, 1'b0, 12'h0A0, 16'h0);
        do_reset(1'b0, 1'b1);
        for (int n = 0; n < 10; n++) begin
            a = 12'($urandom); d = 16'($urandom);
            zw_access(1'b1, 1'b1, a, d);
            zw_access(1'b1, 1'b0, a, 16'h0);
        end
        zw_access(1'b0, 1'b1, 12'h01F, 16'h7E7E);
        zw_access(1'b0, 1'b0, 12'h01F, 16'h0);

        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

endmodule